// File: doc/BRIEF.md
# ECC Error Address Logger

This block keeps a record of where memory ECC errors happen. A memory controller's ECC checker sends it single-bit and multi-bit error strobes, along with the remapped physical address of the failing access and the channel that served it. Because the address has already been remapped, all of physical memory looks like one contiguous range. The block stores the 128-byte (two cache line) address and the channel in a 32-bit capture register that software can read. It also keeps two sticky status flags, one for single-bit errors and one for multi-bit errors.

Capture is gated by the flags. The first error after software has cleared both flags is logged. After that the record is frozen, with one exception: a multi-bit error may replace a record left by a single-bit error. Software reads both registers through a read port with one cycle of latency. It clears each flag by writing a 1 to its status bit. The capture register and the flags are cleared only by the power-good reset. The ordinary reset clears only the read-data output.

Top module: `ecc_err_logger`

## Requirements
- R1: After a power-good reset (`pwrgood_ni` low), the capture register and the status register both read 0.
- R2: The capture register holds the error address bits 31:7 in bits 31:7 and the channel (0 or 1) in bit 0. Bits 6:1 always read 0.
- R3: A single-bit error (`err_sbe_i`) that arrives while both flags are clear is captured, and it sets status bit 0 (the single-bit flag).
- R4: While either flag is set, a single-bit error alone changes neither the address nor the channel. The single-bit flag is still set.
- R5: A multi-bit error (`err_mbe_i`) that arrives while the multi-bit flag is clear is captured, even if a single-bit error has already been logged. It sets status bit 1 (the multi-bit flag).
- R6: While the multi-bit flag is set, no further error of either kind changes the capture register.
- R7: If a single-bit and a multi-bit error arrive in the same cycle, the error is captured as multi-bit and both status bits are set.
- R8: A write to the status register (`rd_sel`/`wr_sel` = 1) clears each flag whose bit is written as 1. Bits written as 0 leave their flag unchanged. Capture is enabled again only once both flags are clear.
- R9: Writes to the capture register (select 0) have no effect on its contents.
- R10: Asserting `rst_ni` clears `rd_data_o` at once and leaves the capture register and the flags unchanged.
- R11: `rd_data_o` shows the selected register one cycle after `rd_en_i` is high. While `rd_en_i` is low it holds its value.
- R12: An error that arrives in the same cycle as a status write that leaves both flags clear is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read path only |
| pwrgood_ni | input | 1 | Active-low asynchronous power-good reset of the capture register and the flags |
| err_sbe_i | input | 1 | Single-bit error strobe |
| err_mbe_i | input | 1 | Multi-bit error strobe |
| err_addr_i | input | 32 | Remapped physical address of the error |
| err_chan_i | input | 1 | Channel of the error |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Read select: 0 = capture register, 1 = status |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write select: 0 = capture register (ignored), 1 = status (write 1 to clear) |
| wr_data_i | input | 32 | Write data; bit 0 clears the single-bit flag and bit 1 clears the multi-bit flag |
| rd_data_o | output | 32 | Read data, registered |

## Verification
A flag that is lost or set wrongly shows up at the next status read. It also shows up as the wrong capture behaviour for the next error: a stuck-clear flag lets a later error overwrite the record, and a stuck-set flag blocks the capture that should follow a clear. Every check therefore pairs each error event with a read of both registers two cycles later. Each scenario is built so that a broken lock, a missing override or a wrong clear priority leaves a different address in the capture register.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_W    = 32;
  localparam int LINE_LSB = 7;
  localparam int STAT_SBE = 0;
  localparam int STAT_MBE = 1;

  typedef enum logic {
    SEL_CAPT = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ecc_log_flags.sv
module ecc_log_flags (
  input  logic       clk_i,
  input  logic       pwrgood_ni,
  input  logic       sbe_i,
  input  logic       mbe_i,
  input  logic [1:0] clr_i,
  output logic       sbe_q_o,
  output logic       mbe_q_o,
  output logic       cap_en_o
);
  logic sbe_q, mbe_q;
  logic sbe_eff, mbe_eff;

  // a clear in the same cycle as an error acts first
  assign sbe_eff = sbe_q & ~clr_i[0];
  assign mbe_eff = mbe_q & ~clr_i[1];

  always_comb begin
    if (mbe_i) cap_en_o = ~mbe_eff;
    else       cap_en_o = sbe_i & ~sbe_eff & ~mbe_eff;
  end

  always_ff @(posedge clk_i or negedge pwrgood_ni) begin
    if (!pwrgood_ni) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end else begin
      sbe_q <= sbe_eff | sbe_i;
      mbe_q <= mbe_eff | mbe_i;
    end
  end

  assign sbe_q_o = sbe_q;
  assign mbe_q_o = mbe_q;

  assert_mbe_sets_R5: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    mbe_i |=> mbe_q);
  assert_both_set_R7: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    (sbe_i && mbe_i) |=> (sbe_q && mbe_q));
  assert_mbe_sticky_R8: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    (mbe_q && !clr_i[1]) |=> mbe_q);
  assert_mbe_locks_R6: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    (mbe_q && !clr_i[1]) |-> !cap_en_o);
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int REG_W    = 32,
  parameter int LINE_LSB = 7
) (
  input  logic                      clk_i,
  input  logic                      pwrgood_ni,
  input  logic                      cap_en_i,
  input  logic [REG_W-1:LINE_LSB]   line_i,
  input  logic                      chan_i,
  output logic [REG_W-1:0]          capt_o
);
  localparam int LINE_W = REG_W - LINE_LSB;
  localparam int RSV_W  = LINE_LSB - 1;

  logic [LINE_W-1:0] line_q;
  logic              chan_q;

  always_ff @(posedge clk_i or negedge pwrgood_ni) begin
    if (!pwrgood_ni) begin
      line_q <= '0;
      chan_q <= 1'b0;
    end else if (cap_en_i) begin
      line_q <= line_i;
      chan_q <= chan_i;
    end
  end

  assign capt_o = {line_q, {RSV_W{1'b0}}, chan_q};

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    !cap_en_i |=> $stable(capt_o));
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [1:0]       wr_clr_i,
  input  logic [REG_W-1:0] capt_i,
  input  logic             sbe_q_i,
  input  logic             mbe_q_i,
  output logic [1:0]       clr_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [REG_W-1:0] stat;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rd_q;

  always_comb begin
    stat           = '0;
    stat[STAT_SBE] = sbe_q_i;
    stat[STAT_MBE] = mbe_q_i;
  end

  assign rd_mux = (rd_sel_i == SEL_STAT) ? stat : capt_i;
  // capture register is read-only: writes with select 0 decode to nothing
  assign clr_o  = (wr_en_i && wr_sel_i == SEL_STAT) ? wr_clr_i : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  assert_capt_wr_R9: assert property (@(posedge clk_i)
    (wr_en_i && wr_sel_i == SEL_CAPT) |-> clr_o == 2'b00);
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwrgood_ni,
  input  logic             err_sbe_i,
  input  logic             err_mbe_i,
  input  logic [REG_W-1:0] err_addr_i,
  input  logic             err_chan_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic             sbe_q, mbe_q, cap_en;
  logic [1:0]       clr;
  logic [REG_W-1:0] capt;
  logic             unused_bits;

  assign unused_bits = ^{err_addr_i[LINE_LSB-1:0], wr_data_i[REG_W-1:2]};

  ecc_log_flags u_flags (
    .clk_i      (clk_i),
    .pwrgood_ni (pwrgood_ni),
    .sbe_i      (err_sbe_i),
    .mbe_i      (err_mbe_i),
    .clr_i      (clr),
    .sbe_q_o    (sbe_q),
    .mbe_q_o    (mbe_q),
    .cap_en_o   (cap_en)
  );

  ecc_log_capture #(.REG_W(REG_W), .LINE_LSB(LINE_LSB)) u_capt (
    .clk_i      (clk_i),
    .pwrgood_ni (pwrgood_ni),
    .cap_en_i   (cap_en),
    .line_i     (err_addr_i[REG_W-1:LINE_LSB]),
    .chan_i     (err_chan_i),
    .capt_o     (capt)
  );

  ecc_log_regif #(.REG_W(REG_W)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_clr_i  (wr_data_i[1:0]),
    .capt_i    (capt),
    .sbe_q_i   (sbe_q),
    .mbe_q_i   (mbe_q),
    .clr_o     (clr),
    .rd_data_o (rd_data_o)
  );

  assert_sbe_capture_R3: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    (!sbe_q && !mbe_q && err_sbe_i && !err_mbe_i)
    |=> (capt[REG_W-1:LINE_LSB] == $past(err_addr_i[REG_W-1:LINE_LSB]) && sbe_q));
  assert_sbe_locked_R4: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    ((sbe_q || mbe_q) && clr == 2'b00 && !err_mbe_i) |=> $stable(capt));
  assert_mbe_override_R5: assert property (@(posedge clk_i) disable iff (!pwrgood_ni)
    (!mbe_q && err_mbe_i) |=> (capt[0] == $past(err_chan_i)));
endmodule

// File: tb/sim_ecc_err_logger.sv
module sim_ecc_err_logger;
  logic        clk = 1'b0;
  logic        rst_n, pwrgood_n;
  logic        sbe, mbe, chan;
  logic [31:0] addr;
  logic        rd_en, rd_sel, wr_en, wr_sel;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_logger u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwrgood_ni(pwrgood_n),
    .err_sbe_i(sbe), .err_mbe_i(mbe), .err_addr_i(addr), .err_chan_i(chan),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus: optional status/capture write plus optional error
  task automatic cyc(input logic we, input logic ws, input logic [31:0] wd,
                     input logic s, input logic m, input logic [31:0] a, input logic c);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    sbe = s; mbe = m; addr = a; chan = c;
    @(negedge clk);
    wr_en = 1'b0; sbe = 1'b0; mbe = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic expect_regs(input string req, input logic [31:0] cap_exp, input logic [31:0] st_exp);
    logic [31:0] d;
    rd(1'b0, d); chk({req, " capture"}, d, cap_exp);
    rd(1'b1, d); chk({req, " status"}, d, st_exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwrgood_n = 1'b0;
    sbe = 0; mbe = 0; chan = 0; addr = '0;
    rd_en = 0; rd_sel = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; pwrgood_n = 1'b1;
    chk("R10 rd_data after reset", rd_data, 32'h0);
    expect_regs("R1", 32'h0, 32'h0);
  endtask

  task automatic t_first_sbe();
    cyc(0, 0, 0, 1, 0, 32'h1234_5678, 1);
    expect_regs("R2 R3", 32'h1234_5601, 32'h1);
  endtask

  task automatic t_sbe_locked();
    cyc(0, 0, 0, 1, 0, 32'hABCD_EF80, 0);
    expect_regs("R4", 32'h1234_5601, 32'h1);
  endtask

  task automatic t_ignored_writes();
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    expect_regs("R9", 32'h1234_5601, 32'h1);
    cyc(1, 1, 32'h0, 0, 0, 0, 0);
    expect_regs("R8 zero write", 32'h1234_5601, 32'h1);
  endtask

  task automatic t_mbe_override();
    cyc(0, 0, 0, 0, 1, 32'h0F0F_0FFF, 0);
    expect_regs("R5", 32'h0F0F_0F80, 32'h3);
  endtask

  task automatic t_mbe_locked();
    cyc(0, 0, 0, 0, 1, 32'h8000_0000, 1);
    cyc(0, 0, 0, 1, 0, 32'h4444_4444, 1);
    cyc(0, 0, 0, 1, 1, 32'h9999_9999, 1);
    expect_regs("R6", 32'h0F0F_0F80, 32'h3);
  endtask

  task automatic t_partial_clear();
    cyc(1, 1, 32'h1, 0, 0, 0, 0);
    expect_regs("R8 clear sbe only", 32'h0F0F_0F80, 32'h2);
    cyc(0, 0, 0, 1, 0, 32'h0000_0055, 1);
    expect_regs("R8 still locked", 32'h0F0F_0F80, 32'h3);
    cyc(1, 1, 32'h3, 0, 0, 0, 0);
    expect_regs("R8 both clear", 32'h0F0F_0F80, 32'h0);
    cyc(0, 0, 0, 1, 0, 32'hFFFF_FFFF, 1);
    expect_regs("R8 rearmed", 32'hFFFF_FF81, 32'h1);
  endtask

  task automatic t_core_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 rd_data cleared", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_regs("R10 kept", 32'hFFFF_FF81, 32'h1);
  endtask

  task automatic t_clear_with_error();
    cyc(1, 1, 32'h1, 1, 0, 32'h2000_0100, 0);
    expect_regs("R12", 32'h2000_0100, 32'h1);
  endtask

  task automatic t_simultaneous();
    cyc(1, 1, 32'h3, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 32'h7777_7700, 1);
    expect_regs("R7", 32'h7777_7701, 32'h3);
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    rd(1'b1, d);
    chk("R11 read status", d, 32'h3);
    cyc(1, 1, 32'h3, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R11 hold", rd_data, 32'h3);
    rd(1'b1, d);
    chk("R11 new read", d, 32'h0);
  endtask

  task automatic t_pwrgood();
    cyc(0, 0, 0, 1, 0, 32'h3333_3380, 1);
    @(negedge clk);
    pwrgood_n = 1'b0;
    @(negedge clk);
    pwrgood_n = 1'b1;
    expect_regs("R1 pwrgood", 32'h0, 32'h0);
  endtask

  initial begin
    t_reset();
    t_first_sbe();
    t_sbe_locked();
    t_ignored_writes();
    t_mbe_override();
    t_mbe_locked();
    t_partial_clear();
    t_core_reset();
    t_clear_with_error();
    t_simultaneous();
    t_read_hold();
    t_pwrgood();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule